// File: doc/BRIEF.md
# Multi-bank address range decoder

This block maps a physical request address onto one of several memory banks. Each bank is described by a 32-bit bank word. The word holds an 8 MiB-aligned base address, a 3-bit size code and a valid bit. A global controller enable gates every bank. When the request strobe is high, the block compares the address with every bank in parallel. One clock later it reports a registered result: whether a bank was hit, the index of the winning bank, the byte offset inside that bank, and whether more than one bank claimed the address.

A separate combinational builder path turns a byte size and a base address into a bank word, so configuration logic can program the decoder. The builder raises an error flag when it is given a size it cannot encode.

Top module: `bank_addr_decoder`

## Requirements
- R1: While reset is applied and after it is released, hit_o, multi_hit_o, result_valid_o, bank_idx_o and offset_o are all zero until the first request is sampled.
- R2: A bank's base is its word bits 31:23 followed by 23 zero bits. Its size is 4 MiB shifted left by the code in word bits 19:17. An address hits the bank when it is greater than or equal to the base and less than base plus size. That sum is evaluated without wrapping past 2^32.
- R3: A bank whose word bit 0 is clear never matches.
- R4: While ctrl_en_i is low, no bank matches, so hit_o is low for every request.
- R5: A bank with size code 7 never matches, whatever its base and valid bit.
- R6: When several banks match, the lowest-numbered bank wins. In that case multi_hit_o is high, and it is low when zero or one bank matches.
- R7: On a hit, bank_idx_o gives the winning bank and offset_o gives the address minus that bank's base. On a miss, both are zero.
- R8: A request sampled at a rising edge produces its result on the outputs after that same edge. result_valid_o is then high for exactly that one cycle. While req_valid_i is low, the result outputs hold their values.
- R9: The builder maps byte sizes to codes as follows: 4 MiB gives 0, 8 MiB gives 1, 16 MiB gives 2, 32 MiB gives 3, 64 MiB gives 4, 128 MiB gives 5 and 256 MiB gives 6. For any other size it outputs an all-zero word and raises build_err_o.
- R10: For a supported size, the built word is (build_base_i AND 0xFF800000) OR (code shifted left by 17) OR 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_en_i | input | 1 | Global controller enable |
| bank_words_i | input | 4x32 | Bank configuration words, bank 0 in the low word |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 32 | Request address |
| result_valid_o | output | 1 | High for one cycle after each sampled request |
| hit_o | output | 1 | The address hit a bank |
| multi_hit_o | output | 1 | More than one bank matched |
| bank_idx_o | output | 2 | Index of the winning bank |
| offset_o | output | 32 | Address minus the winning base |
| build_size_i | input | 32 | Builder byte size |
| build_base_i | input | 32 | Builder base address |
| build_word_o | output | 32 | Built bank word |
| build_err_o | output | 1 | Unsupported builder size |

## Verification
A wrong size shift, a wrong base mask or an off-by-one limit compare shows up at the first address on a bank boundary. It appears as a wrong hit_o or a wrong offset_o in the cycle after that request. The sweeps therefore step through the whole 4 GiB space in 1 MiB strides and alternate between the first and the last byte of each stride. A broken priority chain or multi-hit detector shows up as a wrong bank_idx_o or multi_hit_o on the first request that falls into an overlap. A broken gating term shows up as a spurious hit on a disabled, invalid or reserved-code bank, likewise one cycle after the request.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned BASE_LSB  = 23;
  localparam int unsigned SIZE_LSB  = 17;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned UNIT_LOG2 = 22;
  localparam int unsigned MAX_CODE  = 6;
  localparam logic [CODE_W-1:0] RSVD_CODE = 3'd7;
endpackage

// File: rtl/bank_match.sv
module bank_match
  import bank_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] word_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              match_o,
  output logic [ADDR_W-1:0] offset_o
);
  logic [ADDR_W-1:0] base;
  logic [CODE_W-1:0] code;
  logic [ADDR_W:0]   span;
  logic [ADDR_W:0]   limit;

  always_comb begin
    base  = {word_i[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
    code  = word_i[SIZE_LSB +: CODE_W];
    span  = (ADDR_W+1)'(1) << (UNIT_LOG2 + 32'(code));
    // 33-bit limit: a bank near the top of the space must not wrap
    limit = {1'b0, base} + span;
    match_o = en_i && word_i[0] && (code != RSVD_CODE)
              && (addr_i >= base) && ({1'b0, addr_i} < limit);
    offset_o = addr_i - base;
  end
endmodule

// File: rtl/bank_prio_sel.sv
module bank_prio_sel #(
  parameter int unsigned N_BANKS = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic [N_BANKS-1:0]             match_i,
  input  logic [N_BANKS-1:0][DATA_W-1:0] offset_i,
  output logic                           hit_o,
  output logic                           multi_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [DATA_W-1:0]              offset_o
);
  always_comb begin
    idx_o    = '0;
    offset_o = '0;
    // descending scan: the lowest matching index is written last
    for (int i = N_BANKS - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        idx_o    = IDX_W'(i);
        offset_o = offset_i[i];
      end
    end
    hit_o   = |match_i;
    multi_o = |(match_i & (match_i - N_BANKS'(1)));
  end
endmodule

// File: rtl/bank_word_build.sv
module bank_word_build
  import bank_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] size_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] word_o,
  output logic              err_o
);
  logic [CODE_W-1:0] code;
  logic              ok;

  always_comb begin
    code = '0;
    ok   = 1'b0;
    for (int k = 0; k <= int'(MAX_CODE); k++) begin
      if (size_i == (ADDR_W'(1) << (UNIT_LOG2 + k))) begin
        code = CODE_W'(k);
        ok   = 1'b1;
      end
    end
    word_o = '0;
    if (ok) begin
      word_o = {base_i[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
      word_o[SIZE_LSB +: CODE_W] = code;
      word_o[0] = 1'b1;
    end
    err_o = !ok;
  end
endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
  import bank_dec_pkg::*;
#(
  parameter int unsigned N_BANKS = 4,
  localparam int unsigned IDX_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ctrl_en_i,
  input  logic [N_BANKS-1:0][ADDR_W-1:0] bank_words_i,
  input  logic                           req_valid_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  output logic                           result_valid_o,
  output logic                           hit_o,
  output logic                           multi_hit_o,
  output logic [IDX_W-1:0]               bank_idx_o,
  output logic [ADDR_W-1:0]              offset_o,
  input  logic [ADDR_W-1:0]              build_size_i,
  input  logic [ADDR_W-1:0]              build_base_i,
  output logic [ADDR_W-1:0]              build_word_o,
  output logic                           build_err_o
);
  logic [N_BANKS-1:0]             match;
  logic [N_BANKS-1:0][ADDR_W-1:0] bank_off;
  logic                           sel_hit, sel_multi;
  logic [IDX_W-1:0]               sel_idx;
  logic [ADDR_W-1:0]              sel_off;

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    bank_match u_match (
      .word_i   (bank_words_i[g]),
      .en_i     (ctrl_en_i),
      .addr_i   (req_addr_i),
      .match_o  (match[g]),
      .offset_o (bank_off[g])
    );
  end

  bank_prio_sel #(.N_BANKS(N_BANKS), .DATA_W(ADDR_W)) u_sel (
    .match_i  (match),
    .offset_i (bank_off),
    .hit_o    (sel_hit),
    .multi_o  (sel_multi),
    .idx_o    (sel_idx),
    .offset_o (sel_off)
  );

  bank_word_build u_build (
    .size_i (build_size_i),
    .base_i (build_base_i),
    .word_o (build_word_o),
    .err_o  (build_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_valid_o <= 1'b0;
      hit_o          <= 1'b0;
      multi_hit_o    <= 1'b0;
      bank_idx_o     <= '0;
      offset_o       <= '0;
    end else begin
      result_valid_o <= req_valid_i;
      if (req_valid_i) begin
        hit_o       <= sel_hit;
        multi_hit_o <= sel_multi;
        bank_idx_o  <= sel_hit ? sel_idx : '0;
        offset_o    <= sel_hit ? sel_off : '0;
      end
    end
  end

  AST_DISABLED_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !ctrl_en_i) |=> !hit_o); // R4
  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> $past(req_valid_i)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!result_valid_o && $stable(hit_o) && $stable(offset_o))); // R8
  AST_MULTI_HAS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> hit_o); // R6
  AST_OFFSET_IN_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ({1'b0, offset_o} < ((ADDR_W+1)'(1) << (UNIT_LOG2 + MAX_CODE)))); // R7
  AST_BUILD_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    build_err_o |-> (build_word_o == '0)); // R9
  AST_BUILD_VALID_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !build_err_o |-> build_word_o[0]); // R10
endmodule

// File: tb/sim_bank_addr_decoder.sv
`timescale 1ns/1ps
module sim_bank_addr_decoder;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [3:0][31:0] banks = '0;
  logic             req = 1'b0;
  logic [31:0]      addr = '0;
  logic             rvalid, hit, multi;
  logic [1:0]       idx;
  logic [31:0]      off;
  logic [31:0]      bsize = '0, bbase = '0, bword;
  logic             berr;
  int               n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  bank_addr_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_en_i(en), .bank_words_i(banks),
    .req_valid_i(req), .req_addr_i(addr), .result_valid_o(rvalid),
    .hit_o(hit), .multi_hit_o(multi), .bank_idx_o(idx), .offset_o(off),
    .build_size_i(bsize), .build_base_i(bbase), .build_word_o(bword),
    .build_err_o(berr)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // arithmetic reference of R2..R7
  task automatic model(input logic [31:0] a, output bit h, output bit m,
                       output logic [1:0] ix, output logic [31:0] of);
    int cnt = 0;
    h = 0; m = 0; ix = 0; of = 0;
    for (int i = 0; i < 4; i++) begin
      longint unsigned b  = longint'(banks[i][31:23]) * 64'd8388608;
      longint unsigned sz = 64'd4194304 << banks[i][19:17];
      bit mt = en && banks[i][0] && (banks[i][19:17] != 3'd7)
               && (longint'(a) >= b) && (longint'(a) < b + sz);
      if (mt) begin
        if (cnt == 0) begin ix = 2'(i); of = 32'(longint'(a) - b); end
        cnt++;
      end
    end
    h = (cnt > 0);
    m = (cnt > 1);
  endtask

  task automatic apply(input logic [31:0] a, input string tag);
    bit eh, em; logic [1:0] ei; logic [31:0] eo;
    @(negedge clk); addr = a; req = 1'b1;
    model(a, eh, em, ei, eo);
    @(negedge clk); req = 1'b0;
    check(rvalid && hit == eh && multi == em && idx == ei && off == eo, tag,
          $sformatf("v%0b h%0b m%0b i%0d o%h", rvalid, hit, multi, idx, off),
          $sformatf("v1 h%0b m%0b i%0d o%h", eh, em, ei, eo));
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 4096; k++) begin
      logic [31:0] a = 32'(k) << 20;
      if (k[0]) a = a | 32'h000F_FFFF;
      apply(a, tag);
    end
  endtask

  task automatic build_chk(input logic [31:0] s, input logic [31:0] b);
    logic [31:0] ew = '0; bit ee = 1;
    for (int c = 0; c < 7; c++)
      if (s == (32'd4194304 << c)) begin
        ee = 0;
        ew = (b & 32'hFF80_0000) | (32'(c) << 17) | 32'd1;
      end
    bsize = s; bbase = b; #1;
    check(bword == ew && berr == ee, ee ? "R9 unsupported size" : "R9/R10 built word",
          $sformatf("%h e%0b", bword, berr), $sformatf("%h e%0b", ew, ee));
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic h0; logic [31:0] o0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(!hit && !multi && !rvalid && idx == 0 && off == 0, "R1 reset",
          $sformatf("h%0b m%0b v%0b i%0d o%h", hit, multi, rvalid, idx, off), "all zero");
    rst_n = 1'b1;
    @(negedge clk);
    check(!hit && !rvalid && off == 0, "R1 after release",
          $sformatf("h%0b v%0b o%h", hit, rvalid, off), "zero");

    // R4: valid banks but controller disabled
    banks[0] = 32'h0000_0001; banks[1] = 32'h0080_0003;
    banks[2] = 32'h1000_0001 | (32'd6 << 17); banks[3] = 32'h4000_0000 | (32'd3 << 17);
    en = 1'b0;
    sweep("R4 disabled");

    // R2/R3/R7: disjoint banks, bank 3 invalid
    en = 1'b1;
    sweep("R2/R3/R7 disjoint");

    // R5/R6: overlap, reserved code, top-of-space bank
    banks[0] = 32'h2000_0001 | (32'd2 << 17);
    banks[1] = 32'h2000_0001 | (32'd5 << 17);
    banks[2] = 32'h3000_0001 | (32'd7 << 17);
    banks[3] = 32'hFF80_0001 | (32'd6 << 17);
    sweep("R5/R6 overlap");

    // R6: higher bank fully covers lower bank
    banks[0] = 32'h0000_0000; banks[1] = 32'h0600_0001;
    banks[2] = 32'h0400_0001 | (32'd2 << 17); banks[3] = 32'h0000_0001 | (32'd6 << 17);
    sweep("R6 nested");

    // R8: outputs hold while the strobe is low
    apply(32'h0600_1234, "R8 hit");
    h0 = hit; o0 = off;
    addr = 32'hF000_0000;
    repeat (2) @(negedge clk);
    check(!rvalid && hit == h0 && off == o0, "R8 hold",
          $sformatf("v%0b h%0b o%h", rvalid, hit, off), $sformatf("v0 h%0b o%h", h0, o0));

    // R9/R10: builder sweep
    for (int s = 0; s < 32; s++) begin
      build_chk(32'd1 << s, 32'h1234_5678);
      build_chk(32'd1 << s, 32'hFF80_0000);
      build_chk(32'd1 << s, 32'h007F_FFFF);
    end
    build_chk(32'd0, 32'hFFFF_FFFF);
    build_chk(32'h00C0_0000, 32'h8000_0000);
    build_chk(32'hFFFF_FFFF, 32'h8000_0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule